// File: doc/BRIEF.md
# Single-Hop Flit Retransmission Buffer

This block makes one link between two neighbouring mesh switches reliable at flit granularity. Its sending half accepts a flit from the upstream switch over a valid/ready handshake. It adds one even-parity bit over the data and drives flit plus parity onto the link. It keeps a copy of that flit until the far side answers. A positive answer frees the copy. A negative answer makes the same copy cross the same link again.

The receiving half sits at the input of the downstream switch. It recomputes parity over every arriving flit. One cycle after it samples the flit, it returns an acknowledge or a negative acknowledge on the response wire. Only flits that pass the check are forwarded. Only one flit is in flight per hop, so the sender holds ready low while it waits. A retry counter compares the number of resends against a programmable limit. When a flit is refused once more after the limit is used up, the sender raises a persistent fault, stops resending and accepts nothing more until reset.

The two halves have separate port groups. In a chip the link and the response wire run between two instances placed on either side of the hop.

Top module: `hop_retx_buf`

## Requirements
- R1: Whenever `link_valid` is high, `link_par` makes the total number of ones in {`link_data`, `link_par`} even.
- R2: A flit sampled with `rx_valid` high whose 65 bits {`rx_data`, `rx_par`} hold an odd number of ones yields `rsp_nack`=1 and is not forwarded. A flit with an even count yields `rsp_nack`=0, and `out_valid` rises with `out_data` equal to `rx_data`.
- R3: `rsp_valid`, and `out_valid` for a good flit, are high exactly in the cycle after the one in which `rx_valid` was high, and at no other time.
- R4: `in_ready` is low from the cycle after a flit is accepted until the cycle after its acknowledge arrives. At most one flit is outstanding.
- R5: A negative acknowledge on `rsp_in_valid`/`rsp_in_nack`=1 makes the stored flit appear on the link again in the next cycle with identical data, unless R7 applies.
- R6: An acknowledge (`rsp_in_valid`=1, `rsp_in_nack`=0) releases the copy: `in_ready` is high in the next cycle.
- R7: Each flit may be resent at most `retry_limit` times. A negative acknowledge that arrives once `retry_limit` resends have been made raises `fault` in the next cycle and produces no further link transfer.
- R8: `fault` stays high and `in_ready` stays low until reset. Flits offered on `in_valid` during fault are ignored: no link transfer follows.
- R9: Asserting `rst_n` low clears the stored copy, the retry counter and `fault`. Afterwards `in_ready` is high and `link_valid`, `rsp_valid` and `out_valid` are low.
- R10: A corruption of an even number of data bits is not detected: it is acknowledged and forwarded with the corrupted data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| retry_limit | input | 4 | Maximum resends per flit |
| in_valid | input | 1 | Upstream flit valid |
| in_ready | output | 1 | Sender can take a flit |
| in_data | input | 64 | Upstream flit data |
| link_valid | output | 1 | Flit on the link this cycle |
| link_data | output | 64 | Flit data on the link |
| link_par | output | 1 | Even-parity bit on the link |
| rsp_in_valid | input | 1 | Response from the far side is present |
| rsp_in_nack | input | 1 | 1 = negative acknowledge, 0 = acknowledge |
| fault | output | 1 | Persistent link fault, retry limit exhausted |
| rx_valid | input | 1 | Arriving flit valid |
| rx_data | input | 64 | Arriving flit data |
| rx_par | input | 1 | Arriving parity bit |
| rsp_valid | output | 1 | Response to the far sender is present |
| rsp_nack | output | 1 | 1 = parity error, 0 = accepted |
| out_valid | output | 1 | Checked flit to the downstream switch |
| out_data | output | 64 | Checked flit data |

## Verification
A wrong sender state shows up within two cycles of a response. It appears as a link pulse with changed data, a missing resend after a refusal, or `in_ready` that does not return after an acknowledge. A bad retry count shows as `fault` rising one refusal too early or too late, which the bench spots by counting link transfers per flit. Receiver faults appear in the cycle after the sampled flit as a wrong response polarity or a forwarded bad flit, and the scoreboard queues catch these as ordering or value mismatches.

// File: rtl/hop_retx_pkg.sv
package hop_retx_pkg;
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_SEND  = 2'd1,
    TX_WAIT  = 2'd2,
    TX_FAULT = 2'd3
  } tx_state_e;
endpackage

// File: rtl/hop_rst_sync.sv
module hop_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/hop_parity.sv
module hop_parity #(
  parameter int W = 64
) (
  input  logic [W-1:0] bits,
  output logic         odd
);
  assign odd = ^bits;
endmodule

// File: rtl/hop_tx.sv
module hop_tx
  import hop_retx_pkg::*;
#(
  parameter int W  = 64,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] retry_limit,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  input  logic          rsp_valid,
  input  logic          rsp_nack,
  output logic          link_valid,
  output logic [W-1:0]  link_data,
  output logic          link_par,
  output logic          fault
);
  tx_state_e     state_q, state_d;
  logic [RW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  hold_q;
  logic          hold_par_q;
  logic          cap_en;
  logic          cnt_en;
  logic          in_par;

  hop_parity #(.W(W)) u_gen (.bits(in_data), .odd(in_par));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cap_en  = 1'b0;
    cnt_en  = 1'b0;
    case (state_q)
      TX_IDLE: begin
        if (in_valid) begin
          cap_en  = 1'b1;
          cnt_en  = 1'b1;
          cnt_d   = '0;
          state_d = TX_SEND;
        end
      end
      TX_SEND: state_d = TX_WAIT;
      TX_WAIT: begin
        if (rsp_valid) begin
          if (!rsp_nack) begin
            state_d = TX_IDLE;
          end else if (cnt_q == retry_limit) begin
            state_d = TX_FAULT;
          end else begin
            cnt_en  = 1'b1;
            cnt_d   = cnt_q + 1'b1;
            state_d = TX_SEND;
          end
        end
      end
      default: state_d = TX_FAULT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= TX_IDLE;
      cnt_q      <= '0;
      hold_q     <= '0;
      hold_par_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (cap_en) begin
        hold_q     <= in_data;
        hold_par_q <= in_par;
      end
    end
  end

  assign in_ready   = (state_q == TX_IDLE);
  assign link_valid = (state_q == TX_SEND);
  assign link_data  = hold_q;
  assign link_par   = hold_par_q;
  assign fault      = (state_q == TX_FAULT);
endmodule

// File: rtl/hop_rx.sv
module hop_rx #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_data,
  input  logic         rx_par,
  output logic         rsp_valid,
  output logic         rsp_nack,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  logic         bad;
  logic         rsp_valid_d, rsp_nack_d, out_valid_d;
  logic [W-1:0] out_data_q;

  hop_parity #(.W(W+1)) u_chk (.bits({rx_data, rx_par}), .odd(bad));

  always_comb begin
    rsp_valid_d = rx_valid;
    rsp_nack_d  = rx_valid & bad;
    out_valid_d = rx_valid & ~bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_nack   <= 1'b0;
      out_valid  <= 1'b0;
      out_data_q <= '0;
    end else begin
      rsp_valid <= rsp_valid_d;
      rsp_nack  <= rsp_nack_d;
      out_valid <= out_valid_d;
      if (out_valid_d) out_data_q <= rx_data;
    end
  end

  assign out_data = out_data_q;
endmodule

// File: rtl/hop_retx_buf.sv
module hop_retx_buf #(
  parameter int W  = 64,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] retry_limit,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  output logic          link_valid,
  output logic [W-1:0]  link_data,
  output logic          link_par,
  input  logic          rsp_in_valid,
  input  logic          rsp_in_nack,
  output logic          fault,
  input  logic          rx_valid,
  input  logic [W-1:0]  rx_data,
  input  logic          rx_par,
  output logic          rsp_valid,
  output logic          rsp_nack,
  output logic          out_valid,
  output logic [W-1:0]  out_data
);
  logic rst_n_int;

  hop_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  hop_tx #(.W(W), .RW(RW)) u_tx (
    .clk(clk), .rst_n(rst_n_int), .retry_limit(retry_limit),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .rsp_valid(rsp_in_valid), .rsp_nack(rsp_in_nack),
    .link_valid(link_valid), .link_data(link_data), .link_par(link_par),
    .fault(fault)
  );

  hop_rx #(.W(W)) u_rx (
    .clk(clk), .rst_n(rst_n_int),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_par(rx_par),
    .rsp_valid(rsp_valid), .rsp_nack(rsp_nack),
    .out_valid(out_valid), .out_data(out_data)
  );
endmodule

// File: rtl/hop_retx_buf_chk.sv
module hop_retx_buf_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_ready,
  input logic         link_valid,
  input logic [W-1:0] link_data,
  input logic         link_par,
  input logic         rsp_in_valid,
  input logic         rsp_in_nack,
  input logic         fault,
  input logic         rx_valid,
  input logic [W-1:0] rx_data,
  input logic         rx_par,
  input logic         rsp_valid,
  input logic         rsp_nack,
  input logic         out_valid
);
  a_r1_even_parity: assert property (@(posedge clk) disable iff (!rst_n)
    link_valid |-> (^{link_data, link_par}) == 1'b0);

  a_r2_bad_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && ^{rx_data, rx_par}) |=> (rsp_nack && !out_valid));

  a_r2_good_passed: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !(^{rx_data, rx_par})) |=> (!rsp_nack && out_valid));

  a_r3_rsp_next: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> rsp_valid);

  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> (!rsp_valid && !out_valid));

  a_r4_busy_on_link: assert property (@(posedge clk) disable iff (!rst_n)
    link_valid |-> !in_ready);

  a_r5_resend_same: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_in_valid && rsp_in_nack && !in_ready && !link_valid && !fault)
      |=> ((link_valid && $stable(link_data)) || fault));

  a_r6_ack_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_in_valid && !rsp_in_nack && !in_ready && !link_valid && !fault)
      |=> in_ready);

  a_r8_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);

  a_r8_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!link_valid && !in_ready));
endmodule

bind hop_retx_buf hop_retx_buf_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready),
  .link_valid(link_valid), .link_data(link_data), .link_par(link_par),
  .rsp_in_valid(rsp_in_valid), .rsp_in_nack(rsp_in_nack), .fault(fault),
  .rx_valid(rx_valid), .rx_data(rx_data), .rx_par(rx_par),
  .rsp_valid(rsp_valid), .rsp_nack(rsp_nack), .out_valid(out_valid)
);

// File: tb/hop_retx_buf_tb.sv
module hop_retx_buf_tb;
  localparam int W  = 64;
  localparam int RW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [RW-1:0] retry_limit;
  logic          in_valid;
  logic          in_ready;
  logic [W-1:0]  in_data;
  logic          link_valid;
  logic [W-1:0]  link_data;
  logic          link_par;
  logic          fault;
  logic          rsp_valid, rsp_nack, out_valid;
  logic [W-1:0]  out_data;
  logic [W-1:0]  inj_mask = '0;

  always #4 clk = ~clk;

  hop_retx_buf #(.W(W), .RW(RW)) u_dut (
    .clk(clk), .rst_n(rst_n), .retry_limit(retry_limit),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .link_valid(link_valid), .link_data(link_data), .link_par(link_par),
    .rsp_in_valid(rsp_valid), .rsp_in_nack(rsp_nack), .fault(fault),
    .rx_valid(link_valid), .rx_data(link_data ^ inj_mask), .rx_par(link_par),
    .rsp_valid(rsp_valid), .rsp_nack(rsp_nack),
    .out_valid(out_valid), .out_data(out_data)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int link_cnt = 0;
  logic [W-1:0] mask_q[$];
  logic [W-1:0] exp_out_q[$];
  logic         exp_rsp_q[$];
  logic [W-1:0] cur_flit = '0;
  logic         prev_link = 1'b0;
  logic         prev_ack  = 1'b0;

  task automatic chk(input bit ok, input string tag,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: error injection, scoreboard pops, per-cycle rules
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_link = 1'b0;
      prev_ack  = 1'b0;
      inj_mask  = '0;
    end else begin
      if (prev_link || rsp_valid)
        chk(rsp_valid == prev_link, "R3 response one cycle after flit", W'(rsp_valid), W'(prev_link));
      if (prev_ack)
        chk(in_ready, "R6 ready after ack", W'(in_ready), 64'd1);
      if (rsp_valid) begin
        chk(!in_ready, "R4 ready low while waiting", W'(in_ready), 64'd0);
        if (exp_rsp_q.size() == 0) chk(1'b0, "R2 unexpected response", W'(rsp_nack), 64'd0);
        else begin
          logic e;
          e = exp_rsp_q.pop_front();
          chk(rsp_nack == e, "R2 response polarity", W'(rsp_nack), W'(e));
        end
      end
      if (out_valid) begin
        if (exp_out_q.size() == 0) chk(1'b0, "R2 unexpected forward", out_data, '0);
        else begin
          logic [W-1:0] e;
          e = exp_out_q.pop_front();
          chk(out_data == e, "R2 forwarded data", out_data, e);
        end
      end
      if (link_valid) begin
        link_cnt++;
        chk((^{link_data, link_par}) == 1'b0, "R1 even parity", {63'd0, link_par}, {63'd0, ^link_data});
        chk(link_data == cur_flit, "R5 link carries stored flit", link_data, cur_flit);
        chk(!in_ready, "R4 ready low during transfer", W'(in_ready), 64'd0);
        inj_mask = (mask_q.size() > 0) ? mask_q.pop_front() : '0;
      end else begin
        inj_mask = '0;
      end
      prev_link = link_valid;
      prev_ack  = rsp_valid && !rsp_nack;
    end
  end

  // driver: pushes expectations, then offers the flit
  task automatic send_flit(input logic [W-1:0] d, input int nm,
                           input logic [W-1:0] m0, input logic [W-1:0] m1,
                           input logic [W-1:0] m2, input logic [W-1:0] m3);
    logic [W-1:0] ms [4];
    int nacks;
    ms[0] = m0; ms[1] = m1; ms[2] = m2; ms[3] = m3;
    nacks = 0;
    for (int k = 0; k < nm; k++) begin
      mask_q.push_back(ms[k]);
      exp_rsp_q.push_back(^ms[k]);
      if (!(^ms[k])) begin
        exp_out_q.push_back(d ^ ms[k]);
        break;
      end
      nacks++;
      if (nacks > int'(retry_limit)) break;
    end
    while (!in_ready) @(negedge clk);
    cur_flit = d;
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
    while (!(in_ready || fault)) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(!fault, "R9 fault cleared", W'(fault), 64'd0);
    chk(in_ready, "R9 ready in reset", W'(in_ready), 64'd1);
    chk(!link_valid && !rsp_valid && !out_valid, "R9 outputs idle",
        W'({link_valid, rsp_valid, out_valid}), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    int snap;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; retry_limit = 4'd3;
    repeat (2) @(negedge clk);
    do_reset();

    // R1 R2 R6: clean flits of varied patterns
    send_flit(64'h0, 1, '0, '0, '0, '0);
    send_flit('1, 1, '0, '0, '0, '0);
    send_flit(64'h1, 1, '0, '0, '0, '0);
    send_flit(64'hDEAD_BEEF_0123_4567, 1, '0, '0, '0, '0);
    for (int i = 0; i < 6; i++)
      send_flit((64'hA5 << (i * 8)) | 64'(i), 1, '0, '0, '0, '0);

    // R2 R5: single-bit, then triple-bit corruption, then clean
    send_flit(64'h1234_5678_9ABC_DEF0, 2, 64'h20, '0, '0, '0);
    send_flit(64'h0F0F_0F0F_0F0F_0F0F, 3, 64'h1, 64'h8000_0000_0000_0006, '0, '0);

    // R10: even-count corruption slips through
    send_flit(64'hCAFE_0000_0000_F00D, 1, 64'h0C00, '0, '0, '0);

    // R5: three refusals within a limit of 3, then accepted
    send_flit(64'h5555_AAAA_5555_AAAA, 4, 64'h2, 64'h4, 64'h8, '0);

    // R7: limit 2, every attempt corrupted -> 3 transfers then fault
    retry_limit = 4'd2;
    snap = link_cnt;
    send_flit(64'h7777_0000_7777_0000, 4, 64'h1, 64'h1, 64'h1, 64'h1);
    chk(fault, "R7 fault after limit", W'(fault), 64'd1);
    chk(link_cnt - snap == 3, "R7 transfers per flit", W'(link_cnt - snap), 64'd3);
    snap = link_cnt;
    in_valid = 1'b1; in_data = 64'h9999;
    repeat (10) @(negedge clk);
    in_valid = 1'b0;
    chk(fault, "R8 fault persists", W'(fault), 64'd1);
    chk(!in_ready, "R8 ready low in fault", W'(in_ready), 64'd0);
    chk(link_cnt == snap, "R8 offered flit ignored", W'(link_cnt - snap), 64'd0);

    // R9: reset clears fault; limit 0 faults on first refusal
    do_reset();
    retry_limit = 4'd0;
    snap = link_cnt;
    send_flit(64'h0123, 2, 64'h10, '0, '0, '0);
    chk(fault, "R7 zero limit fault", W'(fault), 64'd1);
    chk(link_cnt - snap == 1, "R7 zero limit single transfer", W'(link_cnt - snap), 64'd1);

    do_reset();
    retry_limit = 4'd3;
    send_flit(64'hFEED, 1, '0, '0, '0, '0);
    repeat (3) @(negedge clk);
    chk(exp_out_q.size() == 0, "R2 forward queue drained", W'(exp_out_q.size()), 64'd0);
    chk(exp_rsp_q.size() == 0, "R3 response queue drained", W'(exp_rsp_q.size()), 64'd0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule